// File: doc/BRIEF.md
# Level-Tagged Overflow Timer

This block is an up-counter with one mode/status register on a small synchronous register bus. The counter advances on single-cycle enable pulses taken from one of four prescaler taps. When it wraps from all-ones to zero, one of two overflow flags is set. The flag chosen depends on the level of an external capture signal at the moment of the wrap. When no counter-clear condition is programmed, the block runs as a plain interval timer, and every wrap sets the low-level flag.

The same register holds the overflow interrupt enable, the tap select, the counter-clear condition and the capture edge select. The capture input passes through a two-stage synchronizer. The synchronized level is used to pick the flag. Edges of the synchronized level can clear the counter, and they raise a one-cycle capture event on the edge chosen in the register.

Software cannot set the overflow flags. A flag is cleared only by a two-step sequence: software first reads the register and sees the flag as 1, then writes 0 to that flag.

Top module: `ovf_tag_timer`

## Requirements
- R1: After reset the register at address 0 reads 0x00, the counter at address 1 reads 0 and `irq` is low.
- R2: Bits 5:0 of address 0 read back what was last written. The counter at address 1 is read-only, and writes to it have no effect.
- R3: The counter increments by one for each cycle in which `tap_pulse[sel]` is high, where `sel` is register bits 1:0. Pulses on the other taps do not change it.
- R4: When bits 3:2 are 00 (interval mode), a wrap from 0xFF to 0x00 sets bit 6, whatever the capture level.
- R5: When bits 3:2 are nonzero (capture mode), a wrap sets bit 7 if the synchronized capture level is high and bit 6 if it is low.
- R6: Writing 1 to bit 7 or bit 6 leaves that flag unchanged. Flags are only set by a wrap.
- R7: A flag clears when 0 is written to its bit and the last read of address 0 since the previous write returned that flag as 1. Any write to address 0 disarms both flags. A read that returned 0 does not arm the flag.
- R8: `irq` equals bit 5 AND (bit 7 OR bit 6).
- R9: Bits 3:2 select the counter-clear condition: 00 none, 01 falling capture edge, 10 rising edge, 11 both edges. A clear sets the counter to 0.
- R10: `capt_evt` pulses for one cycle on each synchronized capture edge of the kind selected by bit 4 (1 = rising, 0 = falling).
- R11: If a wrap sets a flag in the same cycle as a valid clear of that flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address (0 mode/status, 1 counter) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing at address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| capt_in | input | 1 | Asynchronous capture input |
| tap_pulse | input | NUM_TAPS | Single-cycle count enables from the prescaler |
| irq | output | 1 | Overflow interrupt request |
| capt_evt | output | 1 | Selected capture edge event |

## Verification
The bench uses the default parameters: an 8-bit counter, four taps and a two-stage synchronizer. With an 8-bit counter, every wrap is reachable in at most 256 pulses. This lets the bench sweep all 64 control values and every combination of clear mode and edge select under both edge directions. Each test drives the counter to 0xFF and wraps it, so overflow tagging, the arm-then-clear protocol and a wrap that coincides with a clear can all be placed on an exact cycle.

// File: rtl/ovf_tag_pkg.sv
package ovf_tag_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_FH  = 7;
  localparam int BIT_FL  = 6;
  localparam int BIT_IE  = 5;
  localparam int BIT_EDG = 4;
  localparam int CTL_W   = 6;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_FALL = 2'b01,
    CLR_RISE = 2'b10,
    CLR_BOTH = 2'b11
  } clr_mode_e;

  // Does an edge pair hit the programmed clear condition?
  function automatic logic clr_match(clr_mode_e m, logic rise, logic fall);
    case (m)
      CLR_FALL: return fall;
      CLR_RISE: return rise;
      CLR_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

  // Next flag value: hardware set dominates a software clear.
  function automatic logic flag_next(logic cur, logic set, logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/ovf_tag_sync.sv
module ovf_tag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q <= '0;
      prev_q <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], din};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign level = pipe_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/ovf_tag_counter.sv
module ovf_tag_counter #(
  parameter int CNT_W    = 8,
  parameter int NUM_TAPS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic [1:0]          sel,
  input  logic                clr,
  output logic [CNT_W-1:0]    cnt,
  output logic                tick,
  output logic                wrap
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (sel == i[1:0]) tick = tick | taps[i];
    end
  end

  assign wrap = tick & (cnt_q == TOP) & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ovf_tag_regs.sv
module ovf_tag_regs
  import ovf_tag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             rd_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic             wrap,
  input  logic             tag_high,
  output logic [CTL_W-1:0] ctl,
  output logic             flag_h,
  output logic             flag_l,
  output logic             set_h,
  output logic             set_l
);
  logic [CTL_W-1:0] ctl_q;
  logic             fh_q, fl_q, arm_h_q, arm_l_q;
  logic             clr_h, clr_l, interval;

  assign interval = (ctl_q[3:2] == CLR_NONE);
  assign set_h    = wrap & ~interval & tag_high;
  assign set_l    = wrap & (interval | ~tag_high);
  assign clr_h    = wr_ctl & ~wdata[BIT_FH] & arm_h_q;
  assign clr_l    = wr_ctl & ~wdata[BIT_FL] & arm_l_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      fh_q    <= 1'b0;
      fl_q    <= 1'b0;
      arm_h_q <= 1'b0;
      arm_l_q <= 1'b0;
    end else begin
      fh_q <= flag_next(fh_q, set_h, clr_h);
      fl_q <= flag_next(fl_q, set_l, clr_l);
      if (wr_ctl) begin
        ctl_q   <= wdata[CTL_W-1:0];
        arm_h_q <= 1'b0;
        arm_l_q <= 1'b0;
      end else if (rd_ctl) begin
        arm_h_q <= fh_q;
        arm_l_q <= fl_q;
      end
    end
  end

  assign ctl    = ctl_q;
  assign flag_h = fh_q;
  assign flag_l = fl_q;
endmodule

// File: rtl/ovf_tag_timer.sv
module ovf_tag_timer
  import ovf_tag_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int CNT_W       = 8,
  parameter int NUM_TAPS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic                capt_in,
  input  logic [NUM_TAPS-1:0] tap_pulse,
  output logic                irq,
  output logic                capt_evt
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(1);

  logic             capt_lvl, capt_rise, capt_fall;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, wrap_evt, clr_hit;
  logic [CTL_W-1:0] ctl_q;
  logic             flag_h, flag_l, set_h, set_l;
  logic             wr_ctl, rd_ctl;

  assign wr_ctl = bus_wr & (bus_addr == A_CTL);
  assign rd_ctl = bus_rd & (bus_addr == A_CTL);

  ovf_tag_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(capt_in),
    .level(capt_lvl), .rise(capt_rise), .fall(capt_fall)
  );

  assign clr_hit = clr_match(clr_mode_e'(ctl_q[3:2]), capt_rise, capt_fall);

  ovf_tag_counter #(.CNT_W(CNT_W), .NUM_TAPS(NUM_TAPS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .taps(tap_pulse), .sel(ctl_q[1:0]),
    .clr(clr_hit), .cnt(cnt_q), .tick(tick), .wrap(wrap_evt)
  );

  ovf_tag_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .rd_ctl(rd_ctl),
    .wdata(bus_wdata), .wrap(wrap_evt), .tag_high(capt_lvl),
    .ctl(ctl_q), .flag_h(flag_h), .flag_l(flag_l),
    .set_h(set_h), .set_l(set_l)
  );

  always_comb begin
    if (bus_addr == A_CTL)      bus_rdata = {flag_h, flag_l, ctl_q};
    else if (bus_addr == A_CNT) bus_rdata = REG_W'(cnt_q);
    else                        bus_rdata = '0;
  end

  assign irq      = ctl_q[BIT_IE] & (flag_h | flag_l);
  assign capt_evt = ctl_q[BIT_EDG] ? capt_rise : capt_fall;
endmodule

// File: rtl/ovf_tag_timer_chk.sv
module ovf_tag_timer_chk #(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              tick,
  input logic              wrap_evt,
  input logic              clr_hit,
  input logic              flag_h,
  input logic              flag_l,
  input logic              ie,
  input logic              set_h,
  input logic              set_l
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_hit) |=> $stable(cnt));
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == '0));
  p_hw_only_h_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_h) |-> $past(wrap_evt));
  p_hw_only_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_l) |-> $past(wrap_evt));
  p_fall_h_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_h) |-> $past(bus_wr && bus_addr == '0 && !bus_wdata[7]));
  p_fall_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_l) |-> $past(bus_wr && bus_addr == '0 && !bus_wdata[6]));
  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (cnt == '0));
  p_set_wins_h_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_h |=> flag_h);
  p_set_wins_l_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_l |=> flag_l);
endmodule

bind ovf_tag_timer ovf_tag_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq(irq), .cnt(cnt_q), .tick(tick),
  .wrap_evt(wrap_evt), .clr_hit(clr_hit), .flag_h(flag_h),
  .flag_l(flag_l), .ie(ctl_q[5]), .set_h(set_h), .set_l(set_l)
);

// File: tb/ovf_tag_timer_tb.sv
module ovf_tag_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       capt = 1'b0;
  logic [3:0] taps = '0;
  logic       irq, capt_evt;
  int         n_chk = 0, n_fail = 0, evt_cnt = 0;

  always #10 clk = ~clk;

  ovf_tag_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .capt_in(capt),
    .tap_pulse(taps), .irq(irq), .capt_evt(capt_evt)
  );

  always @(posedge clk) if (rst_n && capt_evt) evt_cnt <= evt_cnt + 1;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg();
    @(negedge clk); addr = 2'd0; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic pulse(int k, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); taps[k] = 1'b1;
      @(negedge clk); taps[k] = 1'b0;
    end
  endtask

  task automatic to_count(int target);
    logic [7:0] c;
    peek(2'd1, c);
    pulse(0, (target - int'(c) + 256) % 256);
  endtask

  task automatic set_capt(logic v);
    @(negedge clk); capt = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    logic [7:0] v, c0, c1;
    int ev0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, v); chk("R1 reg", v, 8'h00);
    peek(2'd1, v); chk("R1 cnt", v, 0);
    chk("R1 irq", irq, 0);

    // R2 control bits read back; counter is read-only
    for (int x = 0; x < 64; x++) begin
      wr_reg(2'd0, 8'hC0 | 8'(x));
      peek(2'd0, v); chk("R2 readback", v, x);
    end
    wr_reg(2'd1, 8'h55);
    peek(2'd1, v); chk("R2 cnt write ignored", v, 0);

    // R3 tap select
    for (int s = 0; s < 4; s++) begin
      wr_reg(2'd0, 8'hC0 | 8'(s));
      peek(2'd1, c0);
      pulse(s, 3 + s);
      for (int o = 0; o < 4; o++) if (o != s) pulse(o, 2);
      peek(2'd1, c1);
      chk("R3 count", c1, (int'(c0) + 3 + s) % 256);
    end

    // R4 interval mode: low flag even with capture high
    wr_reg(2'd0, 8'hC0);
    set_capt(1'b1);
    to_count(255);
    peek(2'd0, v); chk("R4 before wrap", v, 8'h00);
    pulse(0, 1);
    peek(2'd0, v); chk("R4 low flag", v, 8'h40);
    peek(2'd1, v); chk("R4 wrapped", v, 0);

    // R6 software cannot set; R7 unarmed zero write ignored
    wr_reg(2'd0, 8'hC0);
    peek(2'd0, v); chk("R6 write one", v, 8'h40);
    wr_reg(2'd0, 8'h00);
    peek(2'd0, v); chk("R7 unarmed clear", v, 8'h40);
    rd_reg();
    wr_reg(2'd0, 8'h00);
    peek(2'd0, v); chk("R7 armed clear", v, 8'h00);

    // R5 capture mode tagging (clear on falling edge)
    wr_reg(2'd0, 8'hC4);
    to_count(255); pulse(0, 1);
    peek(2'd0, v); chk("R5 high tag", v, 8'h84);
    set_capt(1'b0);
    to_count(255); pulse(0, 1);
    peek(2'd0, v); chk("R5 low tag", v, 8'hC4);

    // R7 per-flag clear and disarm by any write
    rd_reg();
    wr_reg(2'd0, 8'h44);
    peek(2'd0, v); chk("R7 clear high only", v, 8'h44);
    wr_reg(2'd0, 8'h04);
    peek(2'd0, v); chk("R7 disarmed by write", v, 8'h44);
    rd_reg(); wr_reg(2'd0, 8'h04);
    peek(2'd0, v); chk("R7 clear low", v, 8'h04);
    rd_reg();
    to_count(255); pulse(0, 1);
    wr_reg(2'd0, 8'h04);
    peek(2'd0, v); chk("R7 zero read no arm", v, 8'h44);

    // R8 interrupt
    chk("R8 irq disabled", irq, 0);
    wr_reg(2'd0, 8'hE4);
    chk("R8 irq enabled", irq, 1);
    rd_reg(); wr_reg(2'd0, 8'h24);
    chk("R8 irq cleared", irq, 0);

    // R11 wrap and valid clear in the same cycle
    to_count(255); pulse(0, 1);
    to_count(255);
    rd_reg();
    @(negedge clk); addr = 2'd0; wdata = 8'h24; wr = 1'b1; taps[0] = 1'b1;
    @(negedge clk); wr = 1'b0; taps[0] = 1'b0;
    peek(2'd0, v); chk("R11 set wins", v, 8'h64);
    rd_reg(); wr_reg(2'd0, 8'h04);
    peek(2'd0, v); chk("R11 cleanup", v, 8'h04);

    // R9 clear modes and R10 edge events
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 2; e++) begin
        wr_reg(2'd0, 8'hC0 | 8'(e << 4) | 8'(m << 2));
        to_count(10);
        ev0 = evt_cnt;
        set_capt(1'b1);
        peek(2'd1, v);
        chk("R9 rising clear", v, (m >= 2) ? 0 : 10);
        chk("R10 rising evt", evt_cnt - ev0, e);
        to_count(20);
        ev0 = evt_cnt;
        set_capt(1'b0);
        peek(2'd1, v);
        chk("R9 falling clear", v, (m == 1 || m == 3) ? 0 : 20);
        chk("R10 falling evt", evt_cnt - ev0, 1 - e);
      end
    end

    summary();
  end
endmodule